// File: doc/BRIEF.md
# Eight-Line Prioritised Interrupt Controller

This block merges eight device request lines into a single interrupt wire toward a processor. A line that goes from low to high leaves a pending bit behind. Of the pending lines that are not masked, the controller picks the one with the highest priority. It raises the interrupt only when that line outranks every interrupt the processor is already servicing.

When the processor acknowledges, the chosen line's pending bit moves into an in-service set. One cycle later the controller returns an 8-bit vector for it. The processor signals end-of-service with a one-cycle strobe, which retires the highest-ranked in-service line.

The controller has two priority schemes. In fixed mode line 0 always ranks first. In rotating mode the ranking shifts after each retirement, so the line just retired becomes the last in rank. A configuration strobe loads the line mask, the vector base and the mode together.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `int_req` and `vec_valid` are 0, no line is pending or in service, all lines are unmasked, the vector base is 0 and fixed mode is active.
- R2: A low-to-high transition on `irq_in[i]` sets line i pending. A level that stays high sets nothing further; a fresh request needs the line to fall and rise again.
- R3: A masked pending line never causes `int_req`, but it stays pending. Clearing its mask bit lets it raise `int_req` from the next cycle.
- R4: In fixed mode line 0 has the highest rank and line 7 the lowest. The vector is `{base[4:0], line[2:0]}`, with the base in bits 7:3 and the line number in bits 2:0.
- R5: `int_req` is 1 exactly when some unmasked pending line ranks strictly above every in-service line. It is also 1 when no line is in service and some unmasked line is pending. A line of equal or lower rank waits until the blocking lines retire.
- R6: An `int_ack` cycle with `int_req` high does three things. It clears the winning line's pending bit and sets its in-service bit. In the next cycle `vec_valid` is 1 for one cycle, and `vec_out` holds the winner's vector.
- R7: An `eoi_in` strobe clears the highest-ranked in-service bit and leaves the other in-service bits unchanged. With nothing in service it has no effect.
- R8: In rotating mode, when end-of-service retires line k, line (k+1) mod 8 becomes the highest rank and line k the lowest.
- R9: An `int_ack` cycle with `int_req` low is ignored. `vec_valid` stays 0 and nothing moves into service.
- R10: A `cfg_we` cycle loads `cfg_mask` (bit i = 1 masks line i), `cfg_base` and `cfg_rotate` (1 = rotating). It also restores line 0 as the highest rank.
- R11: An `eoi_in` in the same cycle as `int_ack` is ignored; only the acknowledge takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Device request lines, edge sensitive |
| cfg_we | input | 1 | Load strobe for mask, base and mode |
| cfg_mask | input | 8 | Mask value, 1 disables a line |
| cfg_base | input | 5 | Upper five bits of every vector |
| cfg_rotate | input | 1 | 1 selects rotating priority |
| int_ack | input | 1 | Processor acknowledge strobe |
| eoi_in | input | 1 | End-of-service strobe |
| int_req | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the last acknowledged line |
| vec_valid | output | 1 | High for one cycle when vec_out is fresh |

## Verification
The hardest state to reach is a nested one. Here a lower-ranked line is already in service, a still lower line is pending and blocked, and a higher line arrives and preempts. Under rotation the rank of each of these lines also depends on the history of retirements. The bench produces this state by raising lines one at a time, with acknowledges and retirements interleaved between them. It also sweeps every non-empty request pattern in fixed mode and every mask value. In rotating mode it drains bursts of all eight lines repeatedly. A bench-side model of pending, in-service, mask and rotation state predicts `int_req` and each vector.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int LINES  = 8;
    localparam int IDX_W  = $clog2(LINES);
    localparam int VEC_W  = 8;
    localparam int BASE_W = VEC_W - IDX_W;

    typedef logic [LINES-1:0] line_vec_t;

    typedef struct packed {
        line_vec_t          irr;
        line_vec_t          isr;
        line_vec_t          mask;
        logic [IDX_W-1:0]   top;
        logic [BASE_W-1:0]  base;
        logic               rot;
        logic [VEC_W-1:0]   vec;
        logic               vld;
    } ctrl_state_t;
endpackage

// File: rtl/irq_edge.sv
module irq_edge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] top,
    output logic         any,
    output logic [W-1:0] idx,
    output logic [W-1:0] rank
);
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        rank = '0;
        for (int j = N - 1; j >= 0; j--) begin
            int p;
            p = (int'(top) + j) % N;
            if (req[p]) begin
                any  = 1'b1;
                idx  = W'(p);
                rank = W'(j);
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LINES-1:0]     irq_in,
    input  logic                 cfg_we,
    input  logic [LINES-1:0]     cfg_mask,
    input  logic [BASE_W-1:0]    cfg_base,
    input  logic                 cfg_rotate,
    input  logic                 int_ack,
    input  logic                 eoi_in,
    output logic                 int_req,
    output logic [VEC_W-1:0]     vec_out,
    output logic                 vec_valid
);
    ctrl_state_t st_d, st_q;

    line_vec_t          rise;
    line_vec_t          live;
    line_vec_t          clr;
    logic               win_any, isr_any, req_ok;
    logic [IDX_W-1:0]   win_idx, win_rank, isr_idx, isr_rank;

    irq_edge #(.N(LINES)) i_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (irq_in),
        .rise (rise)
    );

    assign live = st_q.irr & ~st_q.mask;

    prio_pick #(.N(LINES), .W(IDX_W)) i_pick_req (
        .req (live),
        .top (st_q.top),
        .any (win_any),
        .idx (win_idx),
        .rank(win_rank)
    );

    prio_pick #(.N(LINES), .W(IDX_W)) i_pick_isr (
        .req (st_q.isr),
        .top (st_q.top),
        .any (isr_any),
        .idx (isr_idx),
        .rank(isr_rank)
    );

    always_comb begin
        req_ok = win_any && (!isr_any || (win_rank < isr_rank));
        st_d   = st_q;
        clr    = '0;
        st_d.vld = 1'b0;
        if (int_ack) begin
            if (req_ok) begin
                clr[win_idx]         = 1'b1;
                st_d.isr[win_idx]    = 1'b1;
                st_d.vec             = {st_q.base, win_idx};
                st_d.vld             = 1'b1;
            end
        end else if (eoi_in && isr_any) begin
            st_d.isr[isr_idx] = 1'b0;
            if (st_q.rot) st_d.top = isr_idx + IDX_W'(1);
        end
        st_d.irr = (st_q.irr & ~clr) | rise;
        if (cfg_we) begin
            st_d.mask = cfg_mask;
            st_d.base = cfg_base;
            st_d.rot  = cfg_rotate;
            st_d.top  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign int_req   = req_ok;
    assign vec_out   = st_q.vec;
    assign vec_valid = st_q.vld;

    AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_req) |=> ($countones(st_q.isr) == $past($countones(st_q.isr)) + 1)); // R6
    AST_ACK_GIVES_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_req) |=> vec_valid); // R6
    AST_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !int_req) |=> (!vec_valid && $stable(st_q.isr))); // R9
    AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_in && !int_ack && (st_q.isr != '0)) |=>
        ($countones(st_q.isr) == $past($countones(st_q.isr)) - 1)); // R7
    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> ((st_q.irr & ~st_q.mask) != '0)); // R3
    AST_VALID_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> $past(int_ack)); // R6
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_mask = '0;
    logic [4:0] cfg_base = '0;
    logic       cfg_rotate = 1'b0;
    logic       int_ack = 1'b0;
    logic       eoi_in = 1'b0;
    logic       int_req;
    logic [7:0] vec_out;
    logic       vec_valid;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_irr = '0, m_isr = '0, m_mask = '0, m_prev = '0;
    logic [4:0] m_base = '0;
    logic       m_rot = 1'b0;
    int         m_top = 0;

    always #(CLK_P/2) clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
        .cfg_mask(cfg_mask), .cfg_base(cfg_base), .cfg_rotate(cfg_rotate),
        .int_ack(int_ack), .eoi_in(eoi_in), .int_req(int_req),
        .vec_out(vec_out), .vec_valid(vec_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int best(input logic [7:0] v);
        for (int j = 0; j < 8; j++) begin
            int p;
            p = (m_top + j) % 8;
            if (v[p]) return p;
        end
        return -1;
    endfunction

    function automatic int rnk(input int p);
        return (p - m_top + 8) % 8;
    endfunction

    function automatic bit m_req();
        int w;
        w = best(m_irr & ~m_mask);
        if (w < 0) return 1'b0;
        if (m_isr == 0) return 1'b1;
        return rnk(w) < rnk(best(m_isr));
    endfunction

    // one cycle: drive at a falling edge, update model, check at next falling edge
    task automatic step(input string tag, input logic [7:0] irq, input bit ack, input bit eoi);
        bit   exp_v;
        int   w;
        logic [7:0] rise;
        exp_v = 1'b0;
        w = -1;
        irq_in = irq; int_ack = ack; eoi_in = eoi;
        rise = irq & ~m_prev;
        m_prev = irq;
        if (ack) begin
            if (m_req()) begin
                w = best(m_irr & ~m_mask);
                exp_v = 1'b1;
                m_irr[w] = 1'b0;
                m_isr[w] = 1'b1;
            end
        end else if (eoi && m_isr != 0) begin
            int k;
            k = best(m_isr);
            m_isr[k] = 1'b0;
            if (m_rot) m_top = (k + 1) % 8;
        end
        m_irr = m_irr | rise;
        @(negedge clk);
        int_ack = 1'b0; eoi_in = 1'b0;
        if (ack) begin
            check({tag, " vec_valid"}, 32'(vec_valid), 32'(exp_v));
            if (exp_v) check({tag, " vec_out"}, 32'(vec_out), 32'({m_base, 3'(w)}));
        end
        check({tag, " int_req"}, 32'(int_req), 32'(m_req()));
    endtask

    task automatic cfg(input string tag, input logic [7:0] mk, input logic [4:0] bs, input bit rot);
        cfg_we = 1'b1; cfg_mask = mk; cfg_base = bs; cfg_rotate = rot;
        m_mask = mk; m_base = bs; m_rot = rot; m_top = 0;
        @(negedge clk);
        cfg_we = 1'b0;
        check({tag, " int_req after cfg"}, 32'(int_req), 32'(m_req()));
    endtask

    task automatic drain(input string tag);
        for (int g = 0; g < 40; g++) begin
            if (m_req()) step(tag, m_prev, 1'b1, 1'b0);
            else if (m_isr != 0) step(tag, m_prev, 1'b0, 1'b1);
            else break;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 int_req", 32'(int_req), 32'd0);
        check("R1 vec_valid", 32'(vec_valid), 32'd0);
        step("R1 default unmasked", 8'h80, 1'b0, 1'b0);
        step("R1", 8'h00, 1'b0, 1'b0);
        step("R1 base zero fixed", 8'h00, 1'b1, 1'b0);
        drain("R1");

        // R9 acknowledge with nothing requested
        step("R9 idle ack", 8'h00, 1'b1, 1'b0);
        step("R9 still idle", 8'h00, 1'b0, 1'b0);

        // R4 R5 R6 R7 exhaustive request patterns in fixed mode
        for (int p = 1; p < 256; p++) begin
            cfg("R10", 8'h00, 5'(p ^ 7), 1'b0);
            step("R2 R4 raise", 8'(p), 1'b0, 1'b0);
            step("R5 R4", 8'h00, 1'b0, 1'b0);
            drain("R4 R5 R6 R7 fixed");
        end

        // R3 every mask value
        for (int m = 0; m < 256; m++) begin
            cfg("R10 mask", 8'(m), 5'(m), 1'b0);
            step("R3 raise all", 8'hFF, 1'b0, 1'b0);
            step("R3", 8'h00, 1'b0, 1'b0);
            drain("R3 masked drain");
            cfg("R3 unmask", 8'h00, 5'(m), 1'b0);
            drain("R3 after unmask");
        end

        // R5 nesting and preemption
        cfg("R10", 8'h00, 5'h0A, 1'b0);
        step("R5", 8'h20, 1'b0, 1'b0);
        step("R5", 8'h00, 1'b1, 1'b0);
        step("R5 lower blocked", 8'h80, 1'b0, 1'b0);
        step("R5", 8'h00, 1'b0, 1'b0);
        step("R5 higher preempts", 8'h04, 1'b0, 1'b0);
        step("R5", 8'h00, 1'b1, 1'b0);
        step("R5 equal blocked", 8'h04, 1'b0, 1'b0);
        step("R7 retire top", 8'h00, 1'b0, 1'b1);
        step("R7", 8'h00, 1'b1, 1'b0);
        drain("R5 R7");

        // R2 held level does not re-request
        step("R2", 8'h08, 1'b0, 1'b0);
        step("R2", 8'h08, 1'b1, 1'b0);
        step("R2", 8'h08, 1'b0, 1'b1);
        step("R2 held no new", 8'h08, 1'b0, 1'b0);
        check("R2 held int_req", 32'(int_req), 32'd0);
        step("R2 fall", 8'h00, 1'b0, 1'b0);
        step("R2 rise again", 8'h08, 1'b0, 1'b0);
        check("R2 re-raised", 32'(int_req), 32'd1);
        step("R2", 8'h00, 1'b0, 1'b0);
        drain("R2");

        // R11 ack together with eoi
        step("R11", 8'h10, 1'b0, 1'b0);
        step("R11", 8'h00, 1'b1, 1'b0);
        step("R11", 8'h02, 1'b0, 1'b0);
        step("R11 ack+eoi", 8'h00, 1'b1, 1'b1);
        step("R11 line 3 blocked", 8'h08, 1'b0, 1'b0);
        check("R11 blocked int_req", 32'(int_req), 32'd0);
        step("R11", 8'h00, 1'b0, 1'b0);
        drain("R11");

        // R8 rotating mode bursts
        cfg("R10 rotate", 8'h00, 5'h15, 1'b1);
        for (int r = 0; r < 12; r++) begin
            step("R8 burst", (r % 3 == 0) ? 8'hFF : 8'((r * 37) | 1), 1'b0, 1'b0);
            step("R8", 8'h00, 1'b0, 1'b0);
            drain("R8 rotate");
        end
        step("R8", 8'h01, 1'b0, 1'b0);
        step("R8", 8'h00, 1'b1, 1'b0);
        step("R8 retire 0", 8'h00, 1'b0, 1'b1);
        step("R8 lines 0 and 1", 8'h03, 1'b0, 1'b0);
        step("R8 line 1 first", 8'h00, 1'b1, 1'b0);
        check("R8 vec line1", 32'(vec_out), 32'({5'h15, 3'd1}));
        drain("R8");

        // R10 cfg restores line 0 as highest
        step("R10", 8'h01, 1'b0, 1'b0);
        step("R10", 8'h00, 1'b1, 1'b0);
        step("R10", 8'h00, 1'b0, 1'b1);
        cfg("R10 reload", 8'h00, 5'h03, 1'b1);
        step("R10", 8'h03, 1'b0, 1'b0);
        step("R10 line 0 first", 8'h00, 1'b1, 1'b0);
        check("R10 vec line0", 32'(vec_out), 32'({5'h03, 3'd0}));
        drain("R10");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule